// File: doc/BRIEF.md
# GPIO Port-Change Interrupt Detector

This block watches a six-pin general-purpose port and raises a change flag when an enabled pin no longer matches a stored reference snapshot of the port. Each pin has its own enable bit. The reference is not refreshed every clock. It is reloaded only when software reads or writes the port. Until that access happens, a pin that stays different keeps setting the flag again.

The raw pins pass through a two-flop synchronizer. The synchronized value is what software reads from the port, what the snapshot captures and what the comparison uses. The flag drives a wake request on its own. It drives the interrupt output only while the global interrupt enable is high. The usual service sequence is: access the port (read or write), then clear the flag.

Top module: `gpio_chg_det`

## Requirements
- R1: After reset, the enable register reads 0, the flag, interrupt and wake outputs are 0, and the snapshot is 0.
- R2: The enable register is `REG_W` (8) bits wide. Bits 5..0 hold one enable per pin, with bit n belonging to pin n, and are written on `en_wr_i`. They read back on `en_rdata_o` one cycle after the write. Bits 7..6 always read 0, whatever is written to them.
- R3: A pin whose enable bit is 0 never sets the flag, however far it drifts from the snapshot.
- R4: An enabled pin that differs from the snapshot sets the flag. A change on `pin_i` shows on `flag_o` three rising edges later: two edges for the synchronizer and one for the flag register.
- R5: While an enabled mismatch stands and the port is not accessed, a software clear leaves the flag set.
- R6: A port read or write loads the synchronized pin value into the snapshot on that edge. The mismatch then ends, and a later clear drops the flag on the next edge, where it stays low.
- R7: If a mismatch first appears in the same cycle as a port access, it is taken into the snapshot and never sets the flag.
- R8: When a clear and a hardware set fall in the same cycle, the set wins and the flag stays 1.
- R9: `wake_o` follows the flag. `irq_o` is the flag gated by `gie_i`, and it follows `gie_i` in the same cycle.
- R10: Enabling a pin whose synchronized value already differs from the snapshot sets the flag one edge after the enable register updates, that is, two edges after the write.
- R11: `port_rdata_o` shows a change on `pin_i` two rising edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 6 | Raw port pins |
| port_rd_i | input | 1 | Software port read strobe |
| port_wr_i | input | 1 | Software port write strobe |
| port_rdata_o | output | 6 | Synchronized port value |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| en_rdata_o | output | 8 | Enable register read value |
| flag_clr_i | input | 1 | Software clear of the change flag |
| gie_i | input | 1 | Global interrupt enable |
| flag_o | output | 1 | Port-change flag |
| irq_o | output | 1 | Gated interrupt request |
| wake_o | output | 1 | Wake-from-sleep request |

## Verification
A pin change reaches `port_rdata_o` two edges later and `flag_o` three edges later. An enable write shows on `en_rdata_o` after one edge, and any flag it causes follows one edge after that. A clear or an access takes effect on the next edge, and `irq_o` answers `gie_i` with no delay. The driver stamps every expected value with the cycle in which it falls due, counted from the edge that takes the stimulus. The monitor compares each entry only in that cycle, half a period after the edge. The same-cycle race is hit by starting a port read exactly when the change leaves the synchronizer.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
    localparam int unsigned NPIN_DEF   = 6;
    localparam int unsigned REG_W_DEF  = 8;
    localparam int unsigned STAGES_DEF = 2;
endpackage

// File: rtl/gcd_sync.sv
module gcd_sync #(
    parameter int unsigned W      = gpio_chg_pkg::NPIN_DEF,
    parameter int unsigned STAGES = gpio_chg_pkg::STAGES_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stg_d[s] = din;
        end else begin : g_next
            always_comb stg_d[s] = stg_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_d[s];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gcd_snap.sv
module gcd_snap #(
    parameter int unsigned W = gpio_chg_pkg::NPIN_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_s,
    input  logic [W-1:0] en,
    input  logic         acc,
    output logic [W-1:0] snap,
    output logic         mis_any,
    output logic         set_req
);
    typedef struct packed {
        logic [W-1:0] snap;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] mis;

    always_comb begin
        st_d    = st_q;
        mis     = (pin_s ^ st_q.snap) & en;
        mis_any = |mis;
        set_req = mis_any & ~acc;
        if (acc) st_d.snap = pin_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap = st_q.snap;
endmodule

// File: rtl/gcd_flag.sv
module gcd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flag = 1'b0;
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
    parameter int unsigned NPIN   = gpio_chg_pkg::NPIN_DEF,
    parameter int unsigned REG_W  = gpio_chg_pkg::REG_W_DEF,
    parameter int unsigned STAGES = gpio_chg_pkg::STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  pin_i,
    input  logic             port_rd_i,
    input  logic             port_wr_i,
    output logic [NPIN-1:0]  port_rdata_o,
    input  logic             en_wr_i,
    input  logic [REG_W-1:0] en_wdata_i,
    output logic [REG_W-1:0] en_rdata_o,
    input  logic             flag_clr_i,
    input  logic             gie_i,
    output logic             flag_o,
    output logic             irq_o,
    output logic             wake_o
);
    localparam int unsigned PAD_W = REG_W - NPIN;

    typedef struct packed {
        logic [NPIN-1:0] en;
    } st_t;

    st_t             st_d, st_q;
    logic [NPIN-1:0] pin_s;
    logic [NPIN-1:0] snap;
    logic            acc;
    logic            mis_any;
    logic            set_req;
    logic            flag;
    logic            unused_hi;

    assign unused_hi = ^en_wdata_i[REG_W-1:NPIN];

    always_comb begin
        st_d = st_q;
        if (en_wr_i) st_d.en = en_wdata_i[NPIN-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    gcd_sync #(.W(NPIN), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_i),
        .dout (pin_s)
    );

    assign acc = port_rd_i | port_wr_i;

    gcd_snap #(.W(NPIN)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_s  (pin_s),
        .en     (st_q.en),
        .acc    (acc),
        .snap   (snap),
        .mis_any(mis_any),
        .set_req(set_req)
    );

    gcd_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(set_req),
        .clr_i(flag_clr_i),
        .flag (flag)
    );

    assign port_rdata_o = pin_s;
    assign en_rdata_o   = {{PAD_W{1'b0}}, st_q.en};
    assign flag_o       = flag;
    assign wake_o       = flag;
    assign irq_o        = flag & gie_i;
endmodule

// File: rtl/gpio_chg_det_chk.sv
module gpio_chg_det_chk #(
    parameter int unsigned NPIN  = 6,
    parameter int unsigned REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPIN-1:0]  pin_s,
    input logic [NPIN-1:0]  snap,
    input logic             acc,
    input logic             mis_any,
    input logic             flag_clr_i,
    input logic             gie_i,
    input logic             flag_o,
    input logic             irq_o,
    input logic             wake_o,
    input logic [REG_W-1:0] en_rdata_o
);
    AST_EN_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        en_rdata_o[REG_W-1:NPIN] == '0); // R2

    AST_MISMATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (mis_any && !acc) |=> flag_o); // R4

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o); // R5

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (mis_any && !acc && flag_clr_i) |=> flag_o); // R8

    AST_ACCESS_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (snap == $past(pin_s))); // R6

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && (!mis_any || acc)) |=> !flag_o); // R6

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && (!mis_any || acc)) |=> !flag_o); // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |-> !irq_o); // R9

    AST_WAKE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o == flag_o); // R9
endmodule

bind gpio_chg_det gpio_chg_det_chk #(.NPIN(NPIN), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_s     (pin_s),
    .snap      (snap),
    .acc       (acc),
    .mis_any   (mis_any),
    .flag_clr_i(flag_clr_i),
    .gie_i     (gie_i),
    .flag_o    (flag_o),
    .irq_o     (irq_o),
    .wake_o    (wake_o),
    .en_rdata_o(en_rdata_o)
);

// File: tb/test_gpio_chg_det.sv
`timescale 1ns/1ps
module test_gpio_chg_det;
    localparam int SEL_FLAG = 0;
    localparam int SEL_IRQ  = 1;
    localparam int SEL_WAKE = 2;
    localparam int SEL_RD   = 3;
    localparam int SEL_EN   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pin_i = '0;
    logic       port_rd_i = 1'b0;
    logic       port_wr_i = 1'b0;
    logic [5:0] port_rdata_o;
    logic       en_wr_i = 1'b0;
    logic [7:0] en_wdata_i = '0;
    logic [7:0] en_rdata_o;
    logic       flag_clr_i = 1'b0;
    logic       gie_i = 1'b0;
    logic       flag_o, irq_o, wake_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int         due;
        int         sel;
        logic [7:0] val;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gpio_chg_det i_gpio_chg_det (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .port_rd_i(port_rd_i), .port_wr_i(port_wr_i), .port_rdata_o(port_rdata_o),
        .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i), .en_rdata_o(en_rdata_o),
        .flag_clr_i(flag_clr_i), .gie_i(gie_i),
        .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(input int dly, input int sel, input logic [7:0] v, input string r);
        exp_t e;
        e.due = cyc + dly; e.sel = sel; e.val = v; e.req = r;
        sb.push_back(e);
    endtask

    // monitor: compares each entry half a period after the edge it falls due on
    always @(negedge clk) begin
        #1;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due <= cyc) begin
                logic [7:0] got;
                case (sb[i].sel)
                    SEL_FLAG: got = {7'b0, flag_o};
                    SEL_IRQ:  got = {7'b0, irq_o};
                    SEL_WAKE: got = {7'b0, wake_o};
                    SEL_RD:   got = {2'b0, port_rdata_o};
                    default:  got = en_rdata_o;
                endcase
                n_chk++;
                if (got !== sb[i].val) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d cyc=%0d actual=%0h expected=%0h",
                             sb[i].req, sb[i].sel, cyc, got, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_at(0, SEL_FLAG, 8'h00, "R1");
        expect_at(0, SEL_IRQ,  8'h00, "R1");
        expect_at(0, SEL_WAKE, 8'h00, "R1");
        expect_at(0, SEL_EN,   8'h00, "R1");
        expect_at(0, SEL_RD,   8'h00, "R1");
        tick(1);

        // R2 upper bits read zero
        en_wr_i = 1'b1; en_wdata_i = 8'hFF;
        expect_at(1, SEL_EN, 8'h3F, "R2");
        tick(1);
        en_wdata_i = 8'hC0;
        expect_at(1, SEL_EN, 8'h00, "R2");
        tick(1);
        en_wr_i = 1'b0; tick(1);

        // R3 disabled pin change is ignored; R11 read path latency
        pin_i = 6'h01;
        expect_at(2, SEL_RD,   8'h01, "R11");
        expect_at(3, SEL_FLAG, 8'h00, "R3");
        expect_at(5, SEL_FLAG, 8'h00, "R3");
        tick(6);
        port_rd_i = 1'b1; tick(1); port_rd_i = 1'b0;

        // R10 enabling a matching pin sets nothing
        en_wr_i = 1'b1; en_wdata_i = 8'h01;
        expect_at(1, SEL_EN,   8'h01, "R2");
        expect_at(2, SEL_FLAG, 8'h00, "R10");
        tick(1); en_wr_i = 1'b0; tick(2);

        // R4 enabled change sets flag three edges later; R9 gating
        pin_i = 6'h00;
        expect_at(2, SEL_FLAG, 8'h00, "R4");
        expect_at(3, SEL_FLAG, 8'h01, "R4");
        expect_at(3, SEL_WAKE, 8'h01, "R9");
        expect_at(3, SEL_IRQ,  8'h00, "R9");
        tick(4);
        gie_i = 1'b1;
        expect_at(0, SEL_IRQ, 8'h01, "R9");
        tick(1);

        // R8 set beats clear, R5 clear has no lasting effect
        flag_clr_i = 1'b1;
        expect_at(1, SEL_FLAG, 8'h01, "R8");
        tick(1); flag_clr_i = 1'b0;
        expect_at(1, SEL_FLAG, 8'h01, "R5");
        expect_at(3, SEL_FLAG, 8'h01, "R5");
        tick(3);

        // R6 read reloads snapshot, then clear sticks
        port_rd_i = 1'b1; tick(1); port_rd_i = 1'b0;
        flag_clr_i = 1'b1;
        expect_at(1, SEL_FLAG, 8'h00, "R6");
        tick(1); flag_clr_i = 1'b0;
        expect_at(3, SEL_FLAG, 8'h00, "R6");
        expect_at(3, SEL_IRQ,  8'h00, "R9");
        tick(3);

        // R6 write path
        pin_i = 6'h01;
        expect_at(3, SEL_FLAG, 8'h01, "R4");
        tick(3);
        port_wr_i = 1'b1; tick(1); port_wr_i = 1'b0;
        flag_clr_i = 1'b1;
        expect_at(1, SEL_FLAG, 8'h00, "R6");
        tick(1); flag_clr_i = 1'b0;
        expect_at(2, SEL_FLAG, 8'h00, "R6");
        tick(2);

        // R3 disabled pin1 differs; R10 enabling it raises flag
        pin_i = 6'h03;
        expect_at(3, SEL_FLAG, 8'h00, "R3");
        expect_at(5, SEL_FLAG, 8'h00, "R3");
        tick(5);
        en_wr_i = 1'b1; en_wdata_i = 8'h03;
        expect_at(1, SEL_EN,   8'h03, "R2");
        expect_at(1, SEL_FLAG, 8'h00, "R10");
        expect_at(2, SEL_FLAG, 8'h01, "R10");
        tick(1); en_wr_i = 1'b0; tick(1);
        port_rd_i = 1'b1; tick(1); port_rd_i = 1'b0;
        flag_clr_i = 1'b1;
        expect_at(1, SEL_FLAG, 8'h00, "R6");
        tick(1); flag_clr_i = 1'b0; tick(1);

        // R7 change leaving the synchronizer in a read cycle is absorbed
        pin_i = 6'h02;
        tick(2);
        port_rd_i = 1'b1;
        expect_at(0, SEL_RD,   8'h02, "R11");
        expect_at(1, SEL_FLAG, 8'h00, "R7");
        tick(1); port_rd_i = 1'b0;
        expect_at(2, SEL_FLAG, 8'h00, "R7");
        expect_at(4, SEL_FLAG, 8'h00, "R7");
        tick(6);

        foreach (sb[i]) begin
            n_chk++; n_fail++;
            $display("FAIL %s actual=unchecked expected=due %0d", sb[i].req, sb[i].due);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule